// File: doc/BRIEF.md
# I2C EEPROM Slave Protocol Engine

This block is the bus-facing half of a small serial EEPROM. It samples the two I2C lines with a fast system clock and finds START and STOP conditions. It shifts bytes in and out MSB first and answers a device address byte that carries both select bits and the upper memory-address bits. It drives the acknowledge bit as an open-drain pull-down enable. It runs write transfers, current-address reads, sequential reads and the dummy-write-then-repeated-START random read. It keeps the memory word pointer itself.

On the memory side, each received data byte is offered on a valid/ready write stream. The engine has no clock stretching, so back-pressure is bounded. A write offer must be accepted before the SCL falling edge that opens its acknowledge slot. If it is not, the engine withdraws the offer, drops `wr_valid` in that cycle, answers the byte with NACK and ignores the bus until the next START or STOP.

Reads use a one-cycle request pulse with an address. The controller must take every request and answer it with one `rd_rvalid` pulse. A late answer is not stalled: the engine sends 0xFF instead.

Top module: `i2c_eep_slave`

## Requirements
- R1: SDA falling while SCL is high is a START: from any state it restarts address reception and releases SDA. SDA rising while SCL is high is a STOP: it returns the engine to idle with SDA released. A STOP in the middle of a byte leaves no effect on the next transfer.
- R2: The address byte matches only when bits 7:4 are 1010 and, with MEM_AW=9, bits 3:2 equal `dev_sel[1:0]`. On a mismatch there is no acknowledge, and later bytes are neither acknowledged nor forwarded until START or STOP.
- R3: After a matching address byte, and after each accepted byte of a write transfer, the engine holds `sda_oe` high for the whole ninth SCL clock.
- R4: In a write transfer, bits [MEM_AW-8:1] of the address byte load the upper pointer bits, and the next byte loads pointer bits 7:0. Bit 0 of the address byte is R/W, with 1 meaning read. On a read the upper bits in the address byte are ignored.
- R5: Each later write byte is offered with `wr_valid`, `wr_addr` (the pointer) and `wr_data`, held until `wr_ready`. An offer not taken before the SCL fall that opens the ack slot is withdrawn and NACKed, and nothing is written.
- R6: After each accepted write byte the low PAGE_W (4) pointer bits increment and wrap inside the page. The upper bits stay unchanged.
- R7: A repeated START after the word address, followed by a read address byte, starts reading at the loaded address.
- R8: A read request is issued with the current pointer when a read address is acknowledged, and again after each master ACK. After each request the pointer increments over its full width, with 0x1FF wrapping to 0x000. Data goes out MSB first. A response missing at the SCL fall where sending starts gives 0xFF.
- R9: A master NACK on the ninth read clock makes the engine stop driving SDA until START or STOP. A later current-address read continues from the address after the last byte sent.
- R10: `sda_oe` (1 = pull SDA low) changes only while SCL is low.
- R11: After reset `sda_oe`, `wr_valid` and `rd_req` are low and the pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| sda_oe | output | 1 | Open-drain enable, 1 pulls SDA low |
| dev_sel | input | SELP_W (2) | Hard-wired device select bits |
| wr_valid | output | 1 | Write byte offered |
| wr_ready | input | 1 | Memory takes the write offer |
| wr_addr | output | MEM_AW (9) | Write byte address |
| wr_data | output | 8 | Write byte |
| rd_req | output | 1 | One-cycle read request |
| rd_addr | output | MEM_AW (9) | Read request address |
| rd_rvalid | input | 1 | Read response pulse |
| rd_rdata | input | 8 | Read response byte |

## Verification
Multi-byte writes inside a page and writes that cross a page boundary show whether the low-bit wrap keeps the upper pointer bits. Random reads with ACK then NACK, a current-address read afterwards and a read across the top address show the difference between a page wrap and a full-width increment, and show how the pointer carries over between transfers. Wrong select bits, a wrong device code and a withdrawn write offer each show that muting leaves both the bus and memory untouched. A STOP in the middle of the address byte and a missing read response cover the abort and the 0xFF fill.

// File: rtl/i2c_eep_pkg.sv
package i2c_eep_pkg;
  localparam int BITS_PER_BYTE = 8;
  localparam int CNT_W = 4;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEVADR,
    ST_DEVACK,
    ST_WADR,
    ST_WADRACK,
    ST_WDAT,
    ST_WDATACK,
    ST_TX,
    ST_MACK,
    ST_MUTE
  } eep_state_e;

  typedef enum logic [2:0] {
    PTR_HOLD,
    PTR_LD_HI,
    PTR_LD_LO,
    PTR_INC_PG,
    PTR_INC_ALL
  } ptr_op_e;
endpackage

// File: rtl/i2c_eep_linesync.sv
module i2c_eep_linesync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_lvl,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_c,
  output logic stop_c
);
  logic [STAGES-1:0] scl_ff, sda_ff;
  logic scl_q, sda_q;

  // idle bus is high, so every stage resets to 1
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_i};
      sda_ff <= {sda_ff[STAGES-2:0], sda_i};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_lvl  = scl_ff[STAGES-1];
  assign sda_lvl  = sda_ff[STAGES-1];
  assign scl_rise = scl_lvl & ~scl_q;
  assign scl_fall = ~scl_lvl & scl_q;
  // SDA moves while SCL stays high on both samples
  assign start_c  = scl_lvl & scl_q & sda_q & ~sda_lvl;
  assign stop_c   = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/i2c_eep_devmatch.sv
module i2c_eep_devmatch #(
  parameter  int AW     = 9,
  localparam int HI_W   = AW - 8,
  localparam int SEL_W  = 3 - HI_W,
  localparam int SELP_W = (SEL_W > 0) ? SEL_W : 1
) (
  input  logic [7:0]        abyte,
  input  logic [SELP_W-1:0] dev_sel,
  output logic              hit,
  output logic              rnw,
  output logic [HI_W-1:0]   hi
);
  logic sel_ok;

  generate
    if (SEL_W > 0) begin : g_sel
      assign sel_ok = (abyte[3:HI_W+1] == dev_sel);
    end else begin : g_nosel
      logic unused_sel;
      assign unused_sel = ^dev_sel;
      assign sel_ok = 1'b1;
    end
  endgenerate

  assign hit = (abyte[7:4] == 4'b1010) && sel_ok;
  assign rnw = abyte[0];
  assign hi  = abyte[HI_W:1];
endmodule

// File: rtl/i2c_eep_addrptr.sv
module i2c_eep_addrptr
  import i2c_eep_pkg::*;
#(
  parameter  int AW     = 9,
  parameter  int PAGE_W = 4,
  localparam int HI_W   = AW - 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  ptr_op_e         op,
  input  logic [HI_W-1:0] hi_val,
  input  logic [7:0]      lo_val,
  output logic [AW-1:0]   ptr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else begin
      unique case (op)
        PTR_LD_HI:   ptr[AW-1:8] <= hi_val;
        PTR_LD_LO:   ptr[7:0] <= lo_val;
        PTR_INC_PG:  ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + 1'b1;
        PTR_INC_ALL: ptr <= ptr + 1'b1;
        default:     ;
      endcase
    end
  end

  // R6: a page step never disturbs the bits above the page
  assert_page_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    op == PTR_INC_PG |=> ptr[AW-1:PAGE_W] == $past(ptr[AW-1:PAGE_W]));
endmodule

// File: rtl/i2c_eep_seq.sv
module i2c_eep_seq
  import i2c_eep_pkg::*;
#(
  parameter  int AW   = 9,
  localparam int HI_W = AW - 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_lvl,
  input  logic          sda_lvl,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_c,
  input  logic          stop_c,
  output logic [7:0]    rx_byte,
  input  logic          hit,
  input  logic          rnw,
  output logic          sda_oe,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [7:0]    wr_data,
  output logic          rd_req,
  output logic [AW-1:0] rd_addr,
  input  logic          rd_rvalid,
  input  logic [7:0]    rd_rdata,
  input  logic [AW-1:0] ptr,
  output ptr_op_e       ptr_op
);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BITS_PER_BYTE - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BITS_PER_BYTE);

  eep_state_e       state;
  logic [CNT_W-1:0] bit_cnt;
  logic [7:0]       shreg;
  logic [7:0]       tx_byte;
  logic [7:0]       txb;
  logic             tx_ok;
  logic             is_read;
  logic             wr_took;
  logic             mack_ok;
  logic             accepted;

  assign rx_byte  = shreg;
  assign txb      = tx_ok ? tx_byte : 8'hFF;
  assign accepted = wr_took | (wr_valid & wr_ready);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      tx_byte  <= '0;
      tx_ok    <= 1'b0;
      is_read  <= 1'b0;
      wr_took  <= 1'b0;
      mack_ok  <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
      rd_req   <= 1'b0;
      rd_addr  <= '0;
      ptr_op   <= PTR_HOLD;
    end else begin
      rd_req <= 1'b0;
      ptr_op <= PTR_HOLD;
      if (wr_valid && wr_ready) begin
        wr_valid <= 1'b0;
        wr_took  <= 1'b1;
      end
      if (rd_rvalid) begin
        tx_byte <= rd_rdata;
        tx_ok   <= 1'b1;
      end

      if (start_c) begin
        state    <= ST_DEVADR;
        bit_cnt  <= '0;
        sda_oe   <= 1'b0;
        wr_valid <= 1'b0;
        mack_ok  <= 1'b0;
      end else if (stop_c) begin
        state    <= ST_IDLE;
        sda_oe   <= 1'b0;
        wr_valid <= 1'b0;
        mack_ok  <= 1'b0;
      end else begin
        unique case (state)
          ST_DEVADR, ST_WADR, ST_WDAT: begin
            if (scl_rise && bit_cnt != FULL) begin
              shreg   <= {shreg[6:0], sda_lvl};
              bit_cnt <= bit_cnt + 1'b1;
              if (state == ST_WDAT && bit_cnt == LAST_BIT) begin
                wr_valid <= 1'b1;
                wr_data  <= {shreg[6:0], sda_lvl};
                wr_addr  <= ptr;
                wr_took  <= 1'b0;
              end
            end else if (scl_fall && bit_cnt == FULL) begin
              if (state == ST_DEVADR) begin
                if (hit) begin
                  sda_oe  <= 1'b1;
                  state   <= ST_DEVACK;
                  is_read <= rnw;
                  if (rnw) begin
                    rd_req  <= 1'b1;
                    rd_addr <= ptr;
                    tx_ok   <= 1'b0;
                    ptr_op  <= PTR_INC_ALL;
                  end else begin
                    ptr_op <= PTR_LD_HI;
                  end
                end else begin
                  state <= ST_MUTE;
                end
              end else if (state == ST_WADR) begin
                sda_oe <= 1'b1;
                state  <= ST_WADRACK;
                ptr_op <= PTR_LD_LO;
              end else if (accepted) begin
                sda_oe <= 1'b1;
                state  <= ST_WDATACK;
                ptr_op <= PTR_INC_PG;
              end else begin
                wr_valid <= 1'b0;
                state    <= ST_MUTE;
              end
            end
          end
          ST_DEVACK, ST_WADRACK, ST_WDATACK: begin
            if (scl_fall) begin
              bit_cnt <= '0;
              if (state == ST_DEVACK && is_read) begin
                state  <= ST_TX;
                shreg  <= txb;
                sda_oe <= ~txb[7];
              end else begin
                sda_oe <= 1'b0;
                state  <= (state == ST_DEVACK) ? ST_WADR : ST_WDAT;
              end
            end
          end
          ST_TX: begin
            if (scl_fall) begin
              if (bit_cnt == LAST_BIT - 1'b0 && bit_cnt == LAST_BIT) begin
                sda_oe <= 1'b0;
                state  <= ST_MACK;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
                shreg   <= {shreg[6:0], 1'b1};
                sda_oe  <= ~shreg[6];
              end
            end
          end
          ST_MACK: begin
            if (scl_rise && !mack_ok) begin
              if (!sda_lvl) begin
                mack_ok <= 1'b1;
                rd_req  <= 1'b1;
                rd_addr <= ptr;
                tx_ok   <= 1'b0;
                ptr_op  <= PTR_INC_ALL;
              end else begin
                state <= ST_MUTE;
              end
            end else if (scl_fall && mack_ok) begin
              mack_ok <= 1'b0;
              bit_cnt <= '0;
              state   <= ST_TX;
              shreg   <= txb;
              sda_oe  <= ~txb[7];
            end
          end
          default: ;
        endcase
      end
    end
  end

  // R10: the pull-down is only engaged while the bus clock is low
  assert_oe_rise_scl_low_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_lvl);

  // R2 / R9: a muted engine never pulls the line
  assert_mute_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_MUTE |-> !sda_oe);

  // R5: write offers exist only in the data phase of a write transfer
  assert_wr_offer_phase_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> state == ST_WDAT);

  // R8: read requests follow an acknowledged address or a master ACK
  assert_rdreq_after_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (state == ST_DEVACK || state == ST_MACK));
endmodule

// File: rtl/i2c_eep_slave.sv
module i2c_eep_slave
  import i2c_eep_pkg::*;
#(
  parameter  int MEM_AW      = 9,
  parameter  int PAGE_W      = 4,
  parameter  int SYNC_STAGES = 2,
  localparam int HI_W        = MEM_AW - 8,
  localparam int SEL_W       = 3 - HI_W,
  localparam int SELP_W      = (SEL_W > 0) ? SEL_W : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic [SELP_W-1:0] dev_sel,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [MEM_AW-1:0] wr_addr,
  output logic [7:0]        wr_data,
  output logic              rd_req,
  output logic [MEM_AW-1:0] rd_addr,
  input  logic              rd_rvalid,
  input  logic [7:0]        rd_rdata
);
  logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_c, stop_c;
  logic [7:0] rx_byte;
  logic hit, rnw;
  logic [HI_W-1:0] hi;
  logic [MEM_AW-1:0] ptr;
  ptr_op_e ptr_op;

  i2c_eep_linesync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
    .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
    .scl_fall(scl_fall), .start_c(start_c), .stop_c(stop_c)
  );

  i2c_eep_devmatch #(.AW(MEM_AW)) u_match (
    .abyte(rx_byte), .dev_sel(dev_sel), .hit(hit), .rnw(rnw), .hi(hi)
  );

  i2c_eep_addrptr #(.AW(MEM_AW), .PAGE_W(PAGE_W)) u_ptr (
    .clk(clk), .rst_n(rst_n), .op(ptr_op), .hi_val(hi),
    .lo_val(rx_byte), .ptr(ptr)
  );

  i2c_eep_seq #(.AW(MEM_AW)) u_seq (
    .clk(clk), .rst_n(rst_n), .scl_lvl(scl_lvl), .sda_lvl(sda_lvl),
    .scl_rise(scl_rise), .scl_fall(scl_fall), .start_c(start_c),
    .stop_c(stop_c), .rx_byte(rx_byte), .hit(hit), .rnw(rnw),
    .sda_oe(sda_oe), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata),
    .ptr(ptr), .ptr_op(ptr_op)
  );
endmodule

// File: tb/i2c_eep_slave_bench.sv
`timescale 1ns/1ps
module i2c_eep_slave_bench;
  localparam int H = 20;
  localparam int Q = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, wr_valid, wr_ready, rd_req, rd_rvalid, resp_en;
  logic [1:0] dev_sel;
  logic [8:0] wr_addr, rd_addr;
  logic [7:0] wr_data, rd_rdata;
  logic [7:0] mem [512];
  wire sda_bus = sda_m & ~sda_oe;
  int n_tests = 0, n_fail = 0, wr_cnt = 0, oe_viol = 0;
  logic oe_prev = 1'b0;
  bit done = 0;

  always #2.5 clk = ~clk;

  i2c_eep_slave u_i2c_eep_slave (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_bus), .sda_oe(sda_oe),
    .dev_sel(dev_sel), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_rvalid(rd_rvalid), .rd_rdata(rd_rdata)
  );

  function automatic logic [7:0] init_val(int i);
    return 8'((i * 13 + 7) & 8'hFF);
  endfunction

  // memory model: writes through the stream, reads answered one cycle later
  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 512; i++) mem[i] <= init_val(i);
      rd_rvalid <= 1'b0;
      rd_rdata  <= '0;
    end else begin
      if (wr_valid && wr_ready) begin
        mem[wr_addr] <= wr_data;
        wr_cnt <= wr_cnt + 1;
      end
      rd_rvalid <= rd_req && resp_en;
      rd_rdata  <= mem[rd_addr];
    end
  end

  // R10 monitor: output enable must not move while SCL is high
  always @(negedge clk) begin
    if (rst_n && sda_oe !== oe_prev && scl_m) oe_viol++;
    oe_prev = sda_oe;
  end

  task automatic hold(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(bit ok, string tag, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic m_start();
    hold(Q); sda_m = 1'b1; hold(Q); scl_m = 1'b1; hold(H);
    sda_m = 1'b0; hold(H); scl_m = 1'b0;
  endtask

  task automatic m_stop();
    hold(Q); sda_m = 1'b0; hold(H); scl_m = 1'b1; hold(H);
    sda_m = 1'b1; hold(H);
  endtask

  task automatic m_bit_w(logic b);
    hold(Q); sda_m = b; hold(H); scl_m = 1'b1; hold(H); scl_m = 1'b0;
  endtask

  task automatic m_bit_r(output logic b);
    hold(Q); sda_m = 1'b1; hold(H); scl_m = 1'b1; hold(H / 2);
    b = sda_bus; hold(H / 2); scl_m = 1'b0;
  endtask

  task automatic send_byte(logic [7:0] v, output logic ack);
    logic x;
    for (int i = 7; i >= 0; i--) m_bit_w(v[i]);
    m_bit_r(x);
    ack = !x;
  endtask

  task automatic recv_byte(output logic [7:0] v, input logic give_ack);
    for (int i = 7; i >= 0; i--) m_bit_r(v[i]);
    m_bit_w(!give_ack);
  endtask

  task automatic t_reset_and_current_read();
    logic ack; logic [7:0] d;
    chk(sda_oe == 1'b0, "R11 sda_oe after reset", sda_oe, 0);
    chk(wr_valid == 1'b0 && rd_req == 1'b0, "R11 stream idle after reset",
        {wr_valid, rd_req}, 0);
    m_start(); send_byte(8'hA9, ack);
    chk(ack, "R3 read address acked", ack, 1);
    recv_byte(d, 1'b0); m_stop();
    chk(d == init_val(0), "R11 pointer starts at 0", d, init_val(0));
  endtask

  task automatic t_write_burst();
    logic a0, a1, a2, a3, a4; int c0;
    c0 = wr_cnt;
    m_start(); send_byte(8'hAA, a0); send_byte(8'h25, a1);
    send_byte(8'h11, a2); send_byte(8'h22, a3); send_byte(8'h33, a4); m_stop();
    chk(a0 && a1, "R3 address and word address acked", {a0, a1}, 3);
    chk(a2 && a3 && a4, "R3 data bytes acked", {a2, a3, a4}, 7);
    chk(wr_cnt - c0 == 3, "R5 three write offers taken", wr_cnt - c0, 3);
    chk(mem[9'h125] == 8'h11 && mem[9'h126] == 8'h22 && mem[9'h127] == 8'h33,
        "R4 upper bit and word address", mem[9'h125], 8'h11);
  endtask

  task automatic t_page_roll();
    logic a;
    m_start(); send_byte(8'hA8, a); send_byte(8'h0E, a);
    send_byte(8'h5A, a); send_byte(8'h5B, a); send_byte(8'h5C, a); m_stop();
    chk(mem[9'h00E] == 8'h5A && mem[9'h00F] == 8'h5B, "R6 bytes before wrap",
        mem[9'h00F], 8'h5B);
    chk(mem[9'h000] == 8'h5C, "R6 wrap to page start", mem[9'h000], 8'h5C);
    chk(mem[9'h010] == init_val(16), "R6 next page untouched", mem[9'h010],
        init_val(16));
  endtask

  task automatic t_random_read();
    logic a; logic [7:0] d0, d1, d2; logic x0, x1;
    m_start(); send_byte(8'hAA, a); send_byte(8'h25, a);
    m_start(); send_byte(8'hA9, a);
    chk(a, "R7 read after repeated START acked", a, 1);
    recv_byte(d0, 1'b1); recv_byte(d1, 1'b1); recv_byte(d2, 1'b0);
    m_bit_r(x0); m_bit_r(x1); m_stop();
    chk(d0 == 8'h11, "R7 first byte from loaded address", d0, 8'h11);
    chk(d1 == 8'h22 && d2 == 8'h33, "R8 sequential bytes", {d1, d2}, 16'h2233);
    chk(x0 && x1, "R9 line released after NACK", {x0, x1}, 3);
    m_start(); send_byte(8'hA9, a); recv_byte(d0, 1'b0); m_stop();
    chk(d0 == init_val(9'h128), "R9 current read continues", d0, init_val(9'h128));
  endtask

  task automatic t_mismatch();
    logic a0, a1, a2; int c0;
    c0 = wr_cnt;
    m_start(); send_byte(8'hA6, a0); send_byte(8'h25, a1); send_byte(8'h77, a2);
    m_stop();
    chk(!a0 && !a1 && !a2, "R2 wrong select ignored", {a0, a1, a2}, 0);
    m_start(); send_byte(8'hBA, a0); send_byte(8'h25, a1); m_stop();
    chk(!a0 && !a1, "R2 wrong device code ignored", {a0, a1}, 0);
    chk(wr_cnt == c0 && mem[9'h125] == 8'h11, "R2 memory untouched", wr_cnt - c0, 0);
  endtask

  task automatic t_backpressure();
    logic a0, a1, a2; logic [7:0] d; int c0;
    c0 = wr_cnt;
    wr_ready = 1'b0;
    m_start(); send_byte(8'hA8, a0); send_byte(8'h40, a1); send_byte(8'h99, a2);
    m_stop();
    wr_ready = 1'b1;
    chk(a0 && a1 && !a2, "R5 unaccepted byte NACKed", {a0, a1, a2}, 6);
    chk(wr_cnt == c0 && wr_valid == 1'b0, "R5 offer withdrawn", wr_cnt - c0, 0);
    m_start(); send_byte(8'hA8, a0); send_byte(8'h40, a0);
    m_start(); send_byte(8'hA9, a0); recv_byte(d, 1'b0); m_stop();
    chk(d == init_val(9'h040), "R5 memory keeps old byte", d, init_val(9'h040));
  endtask

  task automatic t_read_wrap();
    logic a; logic [7:0] d0, d1;
    m_start(); send_byte(8'hAA, a); send_byte(8'hFF, a);
    m_start(); send_byte(8'hA9, a);
    recv_byte(d0, 1'b1); recv_byte(d1, 1'b0); m_stop();
    chk(d0 == init_val(9'h1FF), "R8 top address", d0, init_val(9'h1FF));
    chk(d1 == 8'h5C, "R8 full-width wrap to 0", d1, 8'h5C);
  endtask

  task automatic t_late_response();
    logic a; logic [7:0] d;
    resp_en = 1'b0;
    m_start(); send_byte(8'hA9, a); recv_byte(d, 1'b0); m_stop();
    resp_en = 1'b1;
    chk(d == 8'hFF, "R8 missing response gives FF", d, 8'hFF);
  endtask

  task automatic t_stop_abort();
    logic a0, a1, a2;
    m_start(); m_bit_w(1'b1); m_bit_w(1'b0); m_bit_w(1'b1); m_bit_w(1'b0);
    m_stop();
    chk(sda_oe == 1'b0, "R1 released after STOP", sda_oe, 0);
    m_start(); send_byte(8'hA8, a0); send_byte(8'h50, a1); send_byte(8'hC3, a2);
    m_stop();
    chk(a0 && a1 && a2, "R1 transfer after abort acked", {a0, a1, a2}, 7);
    chk(mem[9'h050] == 8'hC3, "R1 write after abort", mem[9'h050], 8'hC3);
  endtask

  initial begin
    wr_ready = 1'b1;
    resp_en  = 1'b1;
    dev_sel  = 2'b10;
    hold(10);
    rst_n = 1'b1;
    hold(10);
    t_reset_and_current_read();
    t_write_burst();
    t_page_roll();
    t_random_read();
    t_mismatch();
    t_backpressure();
    t_read_wrap();
    t_late_response();
    t_stop_abort();
    chk(oe_viol == 0, "R10 output change while SCL high", oe_viol, 0);
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule